// File: doc/BRIEF.md
# Periodic Absolute Timestamp Injector

This block keeps a free-running time counter and, whenever a selected trigger fires, drops a sync message carrying the full counter value into a running trace stream. The trigger comes from a programmable prescaler that fires at a fixed period, from external trigger lines, or from any mix of them. A per-source enable mask chooses which of these count.

Trace messages enter on a valid/ready input. Sync messages and trace messages share one registered output slot. A sync message always wins the slot over a trace message, and the input is held off while one waits. Downstream logic can stall the output. A reader that sees two consecutive sync messages can spread the trace messages between them evenly over the interval.

Top module: `stamp_inject`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid` is 0 after that edge and `in_ready` is 1 once `out_ready` is low or high.
- R2: With no sync message pending, a trace word accepted at an edge (`in_valid` and `in_ready` both high) appears unchanged on `out_data` with `out_valid` high right after that edge.
- R3: A sync message is 40 bits: bits 39:32 hold the opcode 8'hE7, and bits 31:0 hold the counter value.
- R4: The time counter reads 0 in the first cycle after reset is released. It rises by one every clock cycle and wraps at 32 bits. A sync message carries the value it had in the cycle its trigger was sampled, not the value at the time of emission.
- R5: With prescale value P > 0 selected (`trig_sel` bit 0) and the output never stalled, sync messages come out every P cycles. Consecutive ones carry counts that differ by exactly P. P = 1 gives one message per cycle.
- R6: A prescale value of 0 produces no periodic triggers.
- R7: External line `ext_trig[i]` triggers only when `trig_sel[i+1]` is 1. A pulse on an unselected line produces no sync message.
- R8: While a sync message is pending, `in_ready` is 0, and the next free output slot carries that sync message.
- R9: A trigger that arrives while a sync message is pending and not yet emitted adds no second message. The pending message keeps the count from its first trigger.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Trace word offered |
| in_data | input | 40 | Trace word |
| in_ready | output | 1 | Trace word accepted at this edge |
| out_ready | input | 1 | Downstream takes the output word |
| out_valid | output | 1 | Output word present |
| out_data | output | 40 | Merged output word (trace or sync) |
| prescale | input | 16 | Prescaler period in cycles; 0 turns it off |
| trig_sel | input | 5 | Bit 0 enables the prescaler; bit i+1 enables `ext_trig[i]` |
| ext_trig | input | 4 | External trigger lines |

## Verification
The hardest case to reach is a merge: a second trigger has to land while a sync message is pending but cannot leave. That only happens when the output slot is stalled. The stimulus parks a trace word in the output with `out_ready` low, pulses a selected external line twice, and then releases the stall. A single sync message must emerge, carrying the count from the first pulse. Long random stretches with random stalls, prescale values and masks are checked every cycle against a bench model of the requirements.

// File: rtl/stamp_pkg.sv
package stamp_pkg;
  localparam int unsigned STAMP_TS_W  = 32;
  localparam int unsigned STAMP_OP_W  = 8;
  localparam logic [7:0]  STAMP_OPCODE = 8'hE7;
endpackage

// File: rtl/stamp_timebase.sv
module stamp_timebase #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] now
);
  always_ff @(posedge clk) begin
    if (rst) now <= '0;
    else     now <= now + 1'b1;
  end
endmodule

// File: rtl/stamp_prescaler.sv
module stamp_prescaler #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] reload,
  output logic         tick
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};
  logic [W-1:0] phase_q;
  logic         enabled;

  assign enabled = (reload != '0);
  // a shrunk period takes effect at once: any phase at or past the end fires
  assign tick    = enabled && (phase_q >= (reload - ONE));

  always_ff @(posedge clk) begin
    if (rst || !enabled || tick) phase_q <= '0;
    else                         phase_q <= phase_q + ONE;
  end
endmodule

// File: rtl/stamp_trigger.sv
module stamp_trigger #(
  parameter int unsigned N_EXT = 4
) (
  input  logic             tick,
  input  logic [N_EXT-1:0] ext_trig,
  input  logic [N_EXT:0]   trig_sel,
  output logic             fire
);
  logic [N_EXT:0] hits;

  assign hits[0] = tick & trig_sel[0];
  for (genvar i = 0; i < N_EXT; i++) begin : g_ext
    assign hits[i+1] = ext_trig[i] & trig_sel[i+1];
  end

  assign fire = |hits;
endmodule

// File: rtl/stamp_merge.sv
module stamp_merge #(
  parameter int unsigned TS_W   = 32,
  parameter int unsigned OP_W   = 8,
  parameter logic [OP_W-1:0] OPCODE = '1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 fire,
  input  logic [TS_W-1:0]      now,
  input  logic                 in_valid,
  input  logic [OP_W+TS_W-1:0] in_data,
  output logic                 in_ready,
  input  logic                 out_ready,
  output logic                 out_valid,
  output logic [OP_W+TS_W-1:0] out_data,
  output logic                 pend,
  output logic [TS_W-1:0]      cap
);
  logic slot_free, take;

  assign slot_free = !out_valid || out_ready;
  assign take      = slot_free && pend;
  assign in_ready  = slot_free && !pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
      cap  <= '0;
    end else if (fire && (!pend || take)) begin
      pend <= 1'b1;
      cap  <= now;
    end else if (take) begin
      pend <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (slot_free) begin
      if (pend) begin
        out_valid <= 1'b1;
        out_data  <= {OPCODE, cap};
      end else if (in_valid) begin
        out_valid <= 1'b1;
        out_data  <= in_data;
      end else begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/stamp_inject.sv
module stamp_inject #(
  parameter int unsigned TS_W   = stamp_pkg::STAMP_TS_W,
  parameter int unsigned OP_W   = stamp_pkg::STAMP_OP_W,
  parameter int unsigned PRE_W  = 16,
  parameter int unsigned N_EXT  = 4,
  parameter logic [OP_W-1:0] OPCODE = stamp_pkg::STAMP_OPCODE
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [OP_W+TS_W-1:0] in_data,
  output logic                 in_ready,
  input  logic                 out_ready,
  output logic                 out_valid,
  output logic [OP_W+TS_W-1:0] out_data,
  input  logic [PRE_W-1:0]     prescale,
  input  logic [N_EXT:0]       trig_sel,
  input  logic [N_EXT-1:0]     ext_trig
);
  logic [TS_W-1:0] now;
  logic            tick;
  logic            fire;
  logic            ts_pend;
  logic [TS_W-1:0] ts_cap;

  stamp_timebase #(.W(TS_W)) u_time (
    .clk(clk), .rst(rst), .now(now)
  );

  stamp_prescaler #(.W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .reload(prescale), .tick(tick)
  );

  stamp_trigger #(.N_EXT(N_EXT)) u_trig (
    .tick(tick), .ext_trig(ext_trig), .trig_sel(trig_sel), .fire(fire)
  );

  stamp_merge #(.TS_W(TS_W), .OP_W(OP_W), .OPCODE(OPCODE)) u_merge (
    .clk(clk), .rst(rst), .fire(fire), .now(now),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
    .pend(ts_pend), .cap(ts_cap)
  );
endmodule

// File: rtl/stamp_inject_chk.sv
module stamp_inject_chk #(
  parameter int unsigned TS_W  = 32,
  parameter int unsigned OP_W  = 8,
  parameter int unsigned PRE_W = 16,
  parameter logic [OP_W-1:0] OPCODE = '1
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic [OP_W+TS_W-1:0] in_data,
  input logic                 in_ready,
  input logic                 out_ready,
  input logic                 out_valid,
  input logic [OP_W+TS_W-1:0] out_data,
  input logic [PRE_W-1:0]     prescale,
  input logic                 tick,
  input logic                 ts_pend,
  input logic [TS_W-1:0]      ts_cap,
  input logic [TS_W-1:0]      now
);
  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  assert_trace_pass_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid && out_data == $past(in_data));

  assert_stamp_first_R8: assert property (@(posedge clk) disable iff (rst)
    ts_pend && (out_ready || !out_valid) |=>
      out_valid && out_data == {OPCODE, $past(ts_cap)});

  assert_gate_R8: assert property (@(posedge clk) disable iff (rst)
    ts_pend |-> !in_ready);

  assert_merge_R9: assert property (@(posedge clk) disable iff (rst)
    ts_pend && out_valid && !out_ready |=> ts_pend && $stable(ts_cap));

  assert_count_R4: assert property (@(posedge clk) disable iff (rst)
    now != {TS_W{1'b1}} |=> now == $past(now) + 1'b1);

  assert_off_R6: assert property (@(posedge clk) disable iff (rst)
    prescale == '0 |-> !tick);
endmodule

bind stamp_inject stamp_inject_chk #(
  .TS_W(TS_W), .OP_W(OP_W), .PRE_W(PRE_W), .OPCODE(OPCODE)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
  .in_ready(in_ready), .out_ready(out_ready), .out_valid(out_valid),
  .out_data(out_data), .prescale(prescale), .tick(tick),
  .ts_pend(ts_pend), .ts_cap(ts_cap), .now(now)
);

// File: tb/stamp_inject_tb.sv
module stamp_inject_tb;
  localparam int N = 4;
  localparam logic [7:0] OP = 8'hE7;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid, in_ready, out_ready, out_valid;
  logic [39:0] in_data, out_data;
  logic [15:0] prescale;
  logic [N:0]  trig_sel;
  logic [N-1:0] ext_trig;

  stamp_inject u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_ready(out_ready), .out_valid(out_valid),
    .out_data(out_data), .prescale(prescale), .trig_sel(trig_sel),
    .ext_trig(ext_trig)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  string cur_req = "R2";

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  // reference model written from the requirements
  logic [31:0] m_cnt, m_cap;
  logic [15:0] m_pc;
  logic        m_pend, m_ov;
  logic [39:0] m_od;

  function automatic logic model_tick(input logic [15:0] p, input logic [15:0] pc);
    return (p != 0) && (pc >= p - 16'd1);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_cap = 0; m_pc = 0; m_pend = 0; m_ov = 0; m_od = 0;
    end else begin
      logic tk, fire, free, take;
      tk   = model_tick(prescale, m_pc);
      fire = (tk & trig_sel[0]) | (|(ext_trig & trig_sel[N:1]));
      free = !m_ov || out_ready;
      take = free && m_pend;
      if (free) begin
        if (m_pend) begin m_ov = 1; m_od = {OP, m_cap}; end
        else if (in_valid) begin m_ov = 1; m_od = in_data; end
        else m_ov = 0;
      end
      if (fire && (!m_pend || take)) begin m_pend = 1; m_cap = m_cnt; end
      else if (take) m_pend = 0;
      if (prescale == 0 || tk) m_pc = 0; else m_pc = m_pc + 16'd1;
      m_cnt = m_cnt + 32'd1;
    end
  end

  int          n_stamp = 0;
  logic [31:0] last_stamp;
  bit          gap_on = 0;
  int          gap_seen = 0;
  logic [31:0] gap_p;

  task automatic cyc(input logic iv, input logic [39:0] id, input logic ordy,
                     input logic [N-1:0] ext);
    @(negedge clk);
    chk(out_valid == m_ov, cur_req, "out_valid", 64'(out_valid), 64'(m_ov));
    if (m_ov)
      chk(out_data == m_od, cur_req, "out_data", 64'(out_data), 64'(m_od));
    in_valid = iv; in_data = id; out_ready = ordy; ext_trig = ext;
    #1;
    chk(in_ready == ((!m_ov || out_ready) && !m_pend), (m_pend ? "R8" : cur_req),
        "in_ready", 64'(in_ready), 64'((!m_ov || out_ready) && !m_pend));
    if (out_valid && out_ready && out_data[39:32] == OP) begin
      if (gap_on) begin
        if (gap_seen >= 2)
          chk(out_data[31:0] - last_stamp == gap_p, "R5", "stamp gap",
              64'(out_data[31:0] - last_stamp), 64'(gap_p));
        gap_seen++;
      end
      n_stamp++;
      last_stamp = out_data[31:0];
    end
  endtask

  function automatic logic [39:0] rnd_trace();
    return {8'h11, $urandom};
  endfunction

  initial begin
    #(20 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] c1;
    logic [39:0] held;
    void'($urandom(32'd2024));
    rst = 1; in_valid = 0; in_data = 0; out_ready = 0;
    prescale = 0; trig_sel = 0; ext_trig = 0;
    repeat (3) @(negedge clk);
    chk(out_valid == 0, "R1", "out_valid in reset", 64'(out_valid), 0);
    chk(in_ready == 1, "R1", "in_ready in reset", 64'(in_ready), 1);
    rst = 0;

    // R2: plain pass-through
    cur_req = "R2";
    for (int i = 0; i < 200; i++) cyc($urandom % 2, rnd_trace(), 1, 0);

    // R5 and R3: periodic stamps at P=1 and P=4
    cur_req = "R3";
    trig_sel = 5'b00001;
    foreach (gap_p[k]) ;
    for (int p = 1; p <= 4; p += 3) begin
      prescale = 16'(p); gap_p = 32'(p); gap_seen = 0; gap_on = 1;
      for (int i = 0; i < 60; i++) cyc($urandom % 2, rnd_trace(), 1, 0);
      gap_on = 0;
      chk(gap_seen >= 10, "R5", "stamps seen", 64'(gap_seen), 10);
    end

    // R6: prescale 0 gives nothing
    cur_req = "R6";
    prescale = 0;
    for (int i = 0; i < 3; i++) cyc(1, rnd_trace(), 1, 0);
    n_stamp = 0;
    for (int i = 0; i < 100; i++) cyc($urandom % 2, rnd_trace(), 1, 0);
    chk(n_stamp == 0, "R6", "stamps with prescale 0", 64'(n_stamp), 0);

    // R7: unselected lines ignored, selected line triggers
    cur_req = "R7";
    trig_sel = 5'b00100;
    n_stamp = 0;
    for (int i = 0; i < 100; i++) cyc($urandom % 2, rnd_trace(), 1, 4'($urandom) & 4'b1101);
    chk(n_stamp == 0, "R7", "stamps from masked lines", 64'(n_stamp), 0);
    cyc(0, 0, 1, 4'b0010);
    c1 = m_cnt;
    for (int i = 0; i < 4; i++) cyc(0, 0, 1, 0);
    chk(n_stamp == 1, "R7", "stamps from selected line", 64'(n_stamp), 1);
    chk(last_stamp == c1, "R4", "captured count", 64'(last_stamp), 64'(c1));

    // R9/R10: merge under a stall
    cur_req = "R9";
    trig_sel = 5'b00010;
    cyc(1, rnd_trace(), 1, 0);
    cyc(1, rnd_trace(), 1, 0);
    cyc(1, rnd_trace(), 0, 0);
    held = out_data;
    cyc(1, rnd_trace(), 0, 4'b0001);
    c1 = m_cnt;
    cyc(1, rnd_trace(), 0, 0);
    cyc(1, rnd_trace(), 0, 4'b0001);
    for (int i = 0; i < 3; i++) cyc(1, rnd_trace(), 0, 0);
    chk(out_valid && out_data == held, "R10", "held word", 64'(out_data), 64'(held));
    n_stamp = 0;
    for (int i = 0; i < 6; i++) cyc(0, 0, 1, 0);
    chk(n_stamp == 1, "R9", "stamps after merge", 64'(n_stamp), 1);
    chk(last_stamp == c1, "R9", "merged count", 64'(last_stamp), 64'(c1));

    // mixed random
    cur_req = "R8";
    for (int blk = 0; blk < 15; blk++) begin
      prescale = 16'($urandom % 7);
      trig_sel = 5'($urandom);
      for (int i = 0; i < 200; i++)
        cyc($urandom % 2, rnd_trace(), ($urandom % 4) != 0,
            (($urandom % 8) == 0) ? 4'($urandom) : 4'b0);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule